// File: doc/BRIEF.md
# SPI Slave Hold-Condition Controller

This block sits between the pins of a serial flash slave and its command shifter. It samples chip select, serial clock, serial data in and the hold pin on a fast system clock. While the slave is selected, pulling the hold pin low pauses the transfer. The block freezes bit shifting, turns off the serial output driver and ignores serial input and clock activity. When the hold pin is released the transfer resumes from the exact bit where it stopped. Entry to and exit from the paused state only happen while the serial clock is low. A hold pin edge that arrives while the clock is high takes effect at the next low phase.

If the master deselects the slave while the hold is active, the block gives the command logic a one-cycle reset pulse. Any internal program, erase or status write is unaffected, because only the interface path is paused. The block also carries a small receive shifter (most significant bit first) whose gated shift enables show how a paused transfer keeps its bit count.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_active, so_en, iface_rst and rx_done are all 0 while chip select is high.
- R2: With chip select low and the serial clock low, a low hold pin drives hold_active to 1 within SYNC_STAGES+2 system clocks.
- R3: A hold pin that falls while the serial clock is high leaves hold_active at 0 until the clock goes low, and hold_active becomes 1 after that.
- R4: A rising hold pin clears hold_active only while the serial clock is low. If the clock is high, hold_active stays 1 until the clock goes low.
- R5: so_en is 0 while hold_active is 1 or chip select is high, and 1 when the slave is selected and not held. so_data is 0 whenever so_en is 0.
- R6: While hold_active is 1, serial clock edges and serial input produce no shift enable and no received bits.
- R7: The bit count and partial word are kept across a hold, so a word interrupted at any bit position is received intact.
- R8: Chip select rising while hold_active is 1 produces exactly one iface_rst pulse one system clock wide and clears hold_active.
- R9: While chip select is high the hold pin has no effect (hold_active stays 0), and a chip select rise without a hold produces no iface_rst.
- R10: A word of WORD_W bits is shifted in on serial clock rising edges, most significant bit first, and rx_done pulses once when it completes. Deselecting clears a partial count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sclk_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| si_pin | input | 1 | Serial data input pin |
| tx_bit | input | 1 | Output bit from the command logic |
| so_data | output | 1 | Serial output value, 0 when not enabled |
| so_en | output | 1 | Serial output driver enable (0 = high impedance) |
| hold_active | output | 1 | Transfer is paused |
| sclk_rise | output | 1 | Gated serial clock rising-edge enable |
| sclk_fall | output | 1 | Gated serial clock falling-edge enable |
| iface_rst | output | 1 | One-cycle reset to the command logic |
| rx_word | output | WORD_W | Last received word |
| rx_done | output | 1 | Word complete pulse |

## Verification
The bench builds the block with SYNC_STAGES=2 and WORD_W=8. With these values a serial half period of six system clocks covers the whole synchroniser delay, and a hold can be placed before every one of the eight bit positions of a word. The random words mix holds entered with the clock low and the clock high, and they toggle the clock during the pause. Directed cases cover a deselect during a hold, a hold pin kept low across the reset that follows, and a partial word dropped by a deselect.

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sclk_pin,
  input  logic              hold_n_pin,
  input  logic              si_pin,
  input  logic              tx_bit,
  output logic              so_data,
  output logic              so_en,
  output logic              hold_active,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              iface_rst,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_done
);
  localparam int CW   = $clog2(WORD_W);
  localparam int LAST = WORD_W - 1;
  localparam int TOP  = SYNC_STAGES - 1;

  logic [TOP:0] cs_sy, sclk_sy, hold_sy, si_sy;
  logic cs_s, sclk_s, hold_s, si_s, sclk_q, cs_q;
  logic enter_now, leave_now, hold_eff;
  logic [CW-1:0] cnt;
  logic [WORD_W-2:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy   <= '1;
      hold_sy <= '1;
      sclk_sy <= '0;
      si_sy   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      cs_sy   <= {cs_sy[TOP-1:0], cs_n_pin};
      hold_sy <= {hold_sy[TOP-1:0], hold_n_pin};
      sclk_sy <= {sclk_sy[TOP-1:0], sclk_pin};
      si_sy   <= {si_sy[TOP-1:0], si_pin};
      sclk_q  <= sclk_s;
      cs_q    <= cs_s;
    end

  assign cs_s   = cs_sy[TOP];
  assign sclk_s = sclk_sy[TOP];
  assign hold_s = hold_sy[TOP];
  assign si_s   = si_sy[TOP];

  // hold state changes only while the serial clock is low
  assign enter_now = ~cs_s & ~hold_active & ~hold_s & ~sclk_s;
  assign leave_now = hold_active & hold_s & ~sclk_s;
  assign hold_eff  = hold_active | enter_now;

  assign sclk_rise = ~cs_s & ~hold_eff & sclk_s & ~sclk_q;
  assign sclk_fall = ~cs_s & ~hold_eff & ~sclk_s & sclk_q;
  assign so_en     = ~cs_s & ~hold_active;
  assign so_data   = so_en & tx_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_active <= 1'b0;
      iface_rst   <= 1'b0;
    end else begin
      iface_rst <= cs_s & ~cs_q & hold_active;
      if (cs_s)           hold_active <= 1'b0;
      else if (enter_now) hold_active <= 1'b1;
      else if (leave_now) hold_active <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      sr      <= '0;
      rx_word <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (cs_s) cnt <= '0;
      else if (sclk_rise) begin
        sr <= {sr[WORD_W-3:0], si_s};
        if (cnt == CW'(LAST)) begin
          rx_word <= {sr, si_s};
          rx_done <= 1'b1;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end

  p_idle_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> !hold_active && !iface_rst && !rx_done);
  p_enter_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(hold_active) |-> $past(!sclk_s));
  p_exit_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n) $fell(hold_active) |-> $past(cs_s) || $past(!sclk_s));
  p_so_off_r5: assert property (@(posedge clk) disable iff (!rst_n) hold_active |-> !so_en && !so_data);
  p_no_shift_r6: assert property (@(posedge clk) disable iff (!rst_n) hold_active |=> !rx_done || $past(rx_done) == 1'b0 && !hold_active || !$past(hold_active));
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n) hold_active |-> !sclk_rise && !sclk_fall);
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) iface_rst |-> !hold_active ##1 !iface_rst);
  p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> !hold_active);
endmodule

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;
  localparam int W = 8;
  localparam int HP = 6;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, hold_n = 1, si = 0, tx_bit = 1;
  logic so_data, so_en, hold_active, sclk_rise, sclk_fall, iface_rst, rx_done;
  logic [W-1:0] rx_word;
  int checks = 0, errors = 0, rx_cnt = 0, rst_cnt = 0;
  logic [W-1:0] last_rx = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(2), .WORD_W(W)) i_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk), .hold_n_pin(hold_n),
    .si_pin(si), .tx_bit(tx_bit), .so_data(so_data), .so_en(so_en),
    .hold_active(hold_active), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .iface_rst(iface_rst), .rx_word(rx_word), .rx_done(rx_done));

  always @(negedge clk) begin
    if (rx_done) begin rx_cnt++; last_rx = rx_word; end
    if (iface_rst) rst_cnt++;
  end

  function automatic logic exp_bit(logic [W-1:0] d, int i);
    return d[W-1-i];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (HP) @(negedge clk);
  endtask

  task automatic hold_clk_low();
    int n0;
    hold_n = 0; settle();
    chk("R2 hold entry", hold_active, 1);
    chk("R5 so off in hold", so_en, 0);
    n0 = rx_cnt;
    for (int k = 0; k < 3; k++) begin
      si = 1'($urandom); sclk = 1; settle(); sclk = 0; settle();
    end
    chk("R6 no bits in hold", rx_cnt, n0);
    hold_n = 1; settle();
    chk("R4 hold exit", hold_active, 0);
    chk("R5 so back on", so_en, 1);
  endtask

  task automatic hold_clk_high();
    hold_n = 0; settle();
    chk("R3 entry deferred", hold_active, 0);
    sclk = 0; settle();
    chk("R3 entry after low", hold_active, 1);
    si = 1'($urandom); sclk = 1; settle();
    hold_n = 1; settle();
    chk("R4 exit deferred", hold_active, 1);
    sclk = 0; settle();
    chk("R4 exit after low", hold_active, 0);
  endtask

  task automatic send(logic [W-1:0] d, int pos, bit high_var);
    for (int i = 0; i < W; i++) begin
      if (i == pos && !high_var) hold_clk_low();
      si = exp_bit(d, i); settle();
      sclk = 1; settle();
      if (i == pos && high_var) hold_clk_high();
      sclk = 0;
    end
    settle();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 hold reset", hold_active, 0);
    chk("R1 so_en reset", so_en, 0);
    chk("R1 iface_rst reset", iface_rst, 0);
    chk("R1 rx_done reset", rx_done, 0);
    rst_n = 1; settle();
    chk("R1 hold after reset", hold_active, 0);

    hold_n = 0; settle();
    chk("R9 hold ignored deselected", hold_active, 0);
    hold_n = 1; settle();

    for (int t = 0; t < 24; t++) begin
      logic [W-1:0] d;
      int pos, n0;
      bit hv;
      d = W'($urandom);
      pos = int'($urandom_range(0, W));
      hv = 1'($urandom);
      n0 = rx_cnt;
      cs_n = 0; settle();
      chk("R5 so on selected", so_en, 1);
      send(d, pos, hv);
      chk("R10 one word", rx_cnt, n0 + 1);
      chk("R7 word intact", last_rx, d);
      cs_n = 1; settle();
    end

    begin
      int r0;
      r0 = rst_cnt;
      cs_n = 0; settle();
      cs_n = 1; settle();
      chk("R9 no reset without hold", rst_cnt, r0);
      cs_n = 0; settle();
      hold_n = 0; settle();
      chk("R2 entry", hold_active, 1);
      cs_n = 1; settle();
      chk("R8 one reset pulse", rst_cnt, r0 + 1);
      chk("R8 hold cleared", hold_active, 0);
      cs_n = 0; settle();
      chk("R8 paused while pin low", hold_active, 1);
      hold_n = 1; settle();
      chk("R8 resume", hold_active, 0);
      send(8'hA5, W, 0);
      chk("R8 word after reset", last_rx, 8'hA5);
      cs_n = 1; settle();
    end

    begin
      int n0;
      cs_n = 0; settle();
      for (int i = 0; i < 3; i++) begin
        si = 1; settle(); sclk = 1; settle(); sclk = 0;
      end
      cs_n = 1; settle();
      n0 = rx_cnt;
      cs_n = 0; settle();
      send(8'h3C, W, 0);
      chk("R10 partial dropped", last_rx, 8'h3C);
      chk("R10 count", rx_cnt, n0 + 1);
      cs_n = 1; settle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule